// File: doc/BRIEF.md
# Request-Triggered Word DMA Channel

A single channel of a memory-to-memory DMA engine. Software programs a source address, a destination address, a transfer count and a channel control word, and a separate operation register holds a master enable. Once armed, the channel waits for an external request strobe. On each accepted request it copies 16-bit words from a queue-style source port to an incrementing destination address on a simple request/ready memory port.

A write that can start the channel (a control write, or an operation write that turns the master enable on) causes a start check one cycle later. A check passes only while the master enable is on, the transfer-end flag is clear and no words are being moved. A passing check arms the channel if the mode field is legal. Otherwise it raises a configuration error. Each accepted request drains the words queued at that moment, limited by the remaining count. When the count runs out, the channel sets its transfer-end flag and can hold an interrupt until software clears the flag.

Register word addresses on the write and read ports: 0 source address, 1 destination address, 2 transfer count, 3 control, 4 operation (bit 0 is the master enable). Control bits: bit 1 is the transfer-end flag, bit 2 is the interrupt enable, and the mode field is the bits under mask 0x3F08.

Top module: `dma_req_channel`

## Requirements
- R1: After reset, all five registers read zero, and busy_o, irq_o, mem_req_o and cfg_err_o are low.
- R2: A write to the operation register causes a start check only when it sets bit 0 while bit 0 was 0. Rewriting bit 0 as 1 while it is already set has no effect on the channel.
- R3: Any control write causes a start check. No check arms the channel while the master enable is 0.
- R4: Arming clears bits 31:24 of the transfer count register. Bits 23:0 are kept.
- R5: A passing check arms the channel only if control & 0x3F08 == 0x0400. For any other value it sets cfg_err_o and leaves the count untouched. The next control write clears cfg_err_o.
- R6: A request is accepted only when the queued word count is nonzero and a multiple of 4. Otherwise no word moves.
- R7: Each moved word writes the head queue word to the destination address, then adds 2 to the destination and subtracts 1 from the count.
- R8: An accepted request moves min(queued words at acceptance, remaining count) words. Words left in the queue stay there, and the channel waits for the next request.
- R9: When the count reaches zero, the channel sets control bit 1 and stops. irq_o is then high if control bit 2 is set.
- R10: irq_o stays high until software writes control bit 1 as 0. Writing it as 1 leaves the flag unchanged.
- R11: busy_o is high in every cycle in which the channel is moving words, and low while it waits for a request.
- R12: If the last word completes in the same cycle as a control write that clears bit 1, the flag ends up set.
- R13: Arming with a masked count of zero sets the transfer-end flag at once and moves no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read word address |
| rd_data_o | output | 32 | Register read data (combinational) |
| dreq_i | input | 1 | External transfer request strobe |
| fifo_level_i | input | 6 | Number of words queued at the source |
| fifo_data_i | input | 16 | Head word of the source queue |
| fifo_pop_o | output | 1 | Removes the head word |
| mem_req_o | output | 1 | Destination write request |
| mem_addr_o | output | 32 | Destination write address |
| mem_wdata_o | output | 16 | Destination write data |
| mem_ready_i | input | 1 | Destination accepts the write this cycle |
| busy_o | output | 1 | Channel is moving words |
| irq_o | output | 1 | Transfer-end interrupt |
| cfg_err_o | output | 1 | Last start check found an illegal mode |

## Verification
The collision that matters is between completion of the final word and a software write to the control register that clears the transfer-end flag. Both update the same flag bit in the same cycle. The bench holds the destination's ready low to freeze the channel on its last word. It then releases ready on the same clock edge on which a flag-clearing control write is presented. The flag and interrupt must read as set afterwards. A second overlap is a start check that arrives while the channel is already armed and waiting. The bench provokes it by rewriting the count with junk upper bits, and judges which writes re-arm by whether those bits are cleared.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SERVE = 2'd2
  } xfer_st_e;

  localparam logic [2:0] REG_SAR = 3'd0;
  localparam logic [2:0] REG_DAR = 3'd1;
  localparam logic [2:0] REG_TCR = 3'd2;
  localparam logic [2:0] REG_CTL = 3'd3;
  localparam logic [2:0] REG_OPR = 3'd4;

  localparam int CTL_W      = 16;
  localparam int CTL_TE_BIT = 1;
  localparam int CTL_IE_BIT = 2;
  localparam logic [CTL_W-1:0] CTL_MODE_MASK = 16'h3F08;
  localparam logic [CTL_W-1:0] CTL_MODE_REQ  = 16'h0400;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             te_i,
  input  logic             idle_ok_i,
  output logic [AW-1:0]    sar_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             dme_o,
  output logic             ctl_wr_o,
  output logic             dar_wr_o,
  output logic             tcr_wr_o,
  output logic             start_o,
  output logic             cfg_err_o
);
  logic [AW-1:0]    sar_q;
  logic [CTL_W-1:0] ctl_q;
  logic             dme_q, trig_q, err_q;
  logic             opr_wr, qual, mode_ok;

  assign ctl_wr_o = wr_en_i && (wr_addr_i == REG_CTL);
  assign dar_wr_o = wr_en_i && (wr_addr_i == REG_DAR);
  assign tcr_wr_o = wr_en_i && (wr_addr_i == REG_TCR);
  assign opr_wr   = wr_en_i && (wr_addr_i == REG_OPR);

  assign mode_ok = (ctl_q & CTL_MODE_MASK) == CTL_MODE_REQ;
  assign qual    = trig_q && dme_q && !te_i && idle_ok_i;
  assign start_o = qual && mode_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      ctl_q  <= '0;
      dme_q  <= 1'b0;
      trig_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == REG_SAR) sar_q <= wr_data_i;
      if (ctl_wr_o) ctl_q <= wr_data_i[CTL_W-1:0];
      if (opr_wr) dme_q <= wr_data_i[0];
      // only a rising master enable counts as a trigger
      trig_q <= ctl_wr_o || (opr_wr && wr_data_i[0] && !dme_q);
      if (ctl_wr_o) err_q <= 1'b0;
      else if (qual && !mode_ok) err_q <= 1'b1;
    end
  end

  assign sar_o     = sar_q;
  assign ctl_o     = ctl_q;
  assign dme_o     = dme_q;
  assign cfg_err_o = err_q;

  a_r3_start_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_en_i && (wr_addr_i == REG_CTL || wr_addr_i == REG_OPR)));

  a_r5_err_bad_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> ((ctl_q & CTL_MODE_MASK) != CTL_MODE_REQ));
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CNT_W     = 24,
  parameter int LVL_W     = 6,
  parameter int DW        = 16,
  parameter int REQ_QUANT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ctl_wr_i,
  input  logic             te_wdata_i,
  input  logic             dar_wr_i,
  input  logic             tcr_wr_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic             ie_i,
  input  logic             dreq_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic             fifo_pop_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ready_i,
  output logic [AW-1:0]    dar_o,
  output logic [AW-1:0]    tcr_o,
  output logic             te_o,
  output logic             busy_o,
  output logic             idle_ok_o,
  output logic             irq_o
);
  localparam logic [AW-1:0] CNT_MASK  = AW'((64'd1 << CNT_W) - 64'd1);
  localparam logic [AW-1:0] ADDR_STEP = AW'(DW / 8);

  xfer_st_e         st_q, st_d;
  logic [AW-1:0]    dar_q, tcr_q, arm_cnt;
  logic [LVL_W-1:0] batch_q;
  logic             te_q, te_set, step, lvl_ok;

  assign arm_cnt = tcr_q & CNT_MASK;
  assign lvl_ok  = (fifo_level_i != '0) &&
                   ((fifo_level_i % LVL_W'(REQ_QUANT)) == '0);
  assign mem_req_o = (st_q == ST_SERVE);
  assign step      = mem_req_o && mem_ready_i;

  always_comb begin
    st_d   = st_q;
    te_set = 1'b0;
    if (start_i) begin
      if (arm_cnt == '0) begin
        st_d   = ST_IDLE;
        te_set = 1'b1;
      end else begin
        st_d = ST_WAIT;
      end
    end else if (st_q == ST_WAIT && dreq_i && lvl_ok) begin
      st_d = ST_SERVE;
    end else if (step) begin
      if (tcr_q == AW'(1)) begin
        st_d   = ST_IDLE;
        te_set = 1'b1;
      end else if (batch_q == LVL_W'(1)) begin
        st_d = ST_WAIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dar_q   <= '0;
      tcr_q   <= '0;
      batch_q <= '0;
      te_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      // completion outranks a clearing write
      te_q <= te_set || (te_q && !(ctl_wr_i && !te_wdata_i));
      if (step) dar_q <= dar_q + ADDR_STEP;
      else if (dar_wr_i) dar_q <= wdata_i;
      if (step) tcr_q <= tcr_q - AW'(1);
      else if (start_i) tcr_q <= arm_cnt;
      else if (tcr_wr_i) tcr_q <= wdata_i;
      if (st_q == ST_WAIT && st_d == ST_SERVE) batch_q <= fifo_level_i;
      else if (step) batch_q <= batch_q - LVL_W'(1);
    end
  end

  assign fifo_pop_o  = step;
  assign mem_addr_o  = dar_q;
  assign mem_wdata_o = fifo_data_i;
  assign dar_o       = dar_q;
  assign tcr_o       = tcr_q;
  assign te_o        = te_q;
  assign busy_o      = (st_q == ST_SERVE);
  assign idle_ok_o   = (st_q != ST_SERVE);
  assign irq_o       = te_q && ie_i;

  a_r7_dar_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> dar_q == $past(dar_q) + ADDR_STEP);

  a_r7_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> tcr_q == $past(tcr_q) - AW'(1));

  a_r4_cnt_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tcr_q & ~CNT_MASK) == '0);

  a_r6_batch_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fifo_level_i != '0 &&
                            (fifo_level_i % LVL_W'(REQ_QUANT)) == '0));

  a_r8_pop_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> fifo_level_i != '0);

  a_r9_te_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_q) |-> $past(step || start_i));
endmodule

// File: rtl/dma_req_channel.sv
module dma_req_channel
  import dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int LVL_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [AW-1:0]    rd_data_o,
  input  logic             dreq_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic             fifo_pop_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             irq_o,
  output logic             cfg_err_o
);
  logic [AW-1:0]    sar, dar, tcr;
  logic [CTL_W-1:0] ctl, ctl_rb;
  logic dme, ctl_wr, dar_wr, tcr_wr, start, te, idle_ok;

  dma_regs #(.AW(AW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .te_i      (te),
    .idle_ok_i (idle_ok),
    .sar_o     (sar),
    .ctl_o     (ctl),
    .dme_o     (dme),
    .ctl_wr_o  (ctl_wr),
    .dar_wr_o  (dar_wr),
    .tcr_wr_o  (tcr_wr),
    .start_o   (start),
    .cfg_err_o (cfg_err_o)
  );

  dma_xfer #(.AW(AW), .CNT_W(CNT_W), .LVL_W(LVL_W), .DW(DW)) i_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .ctl_wr_i     (ctl_wr),
    .te_wdata_i   (wr_data_i[CTL_TE_BIT]),
    .dar_wr_i     (dar_wr),
    .tcr_wr_i     (tcr_wr),
    .wdata_i      (wr_data_i),
    .ie_i         (ctl[CTL_IE_BIT]),
    .dreq_i       (dreq_i),
    .fifo_level_i (fifo_level_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_pop_o   (fifo_pop_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .dar_o        (dar),
    .tcr_o        (tcr),
    .te_o         (te),
    .busy_o       (busy_o),
    .idle_ok_o    (idle_ok),
    .irq_o        (irq_o)
  );

  always_comb begin
    ctl_rb = ctl;
    ctl_rb[CTL_TE_BIT] = te;
    case (rd_addr_i)
      REG_SAR: rd_data_o = sar;
      REG_DAR: rd_data_o = dar;
      REG_TCR: rd_data_o = tcr;
      REG_CTL: rd_data_o = AW'(ctl_rb);
      REG_OPR: rd_data_o = AW'(dme);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: tb/test_dma_req_channel.sv
module test_dma_req_channel;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 6;
  localparam logic [2:0] A_SAR = 3'd0, A_DAR = 3'd1, A_TCR = 3'd2,
                         A_CTL = 3'd3, A_OPR = 3'd4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic dreq_i = 1'b0;
  logic [LVL_W-1:0] fifo_level_i;
  logic [15:0] fifo_data_i, mem_wdata_o;
  logic fifo_pop_o, mem_req_o, mem_ready_i, busy_o, irq_o, cfg_err_o;
  logic [31:0] mem_addr_o;

  logic [15:0] fq [0:63];
  logic [31:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  int head, tail, nlog;
  logic clr = 1'b0, hold_rdy = 1'b0, stall_mode = 1'b0;
  logic [7:0] cyc = '0;
  logic [7:0] cid = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(negedge clk_i) cyc <= cyc + 8'd1;

  assign fifo_level_i = LVL_W'(tail - head);
  assign fifo_data_i  = fq[head % 64];
  assign mem_ready_i  = mem_req_o && !hold_rdy && (!stall_mode || cyc[0]);

  always @(posedge clk_i) begin
    if (clr) begin
      head <= 0;
      nlog <= 0;
    end else if (mem_req_o && mem_ready_i) begin
      log_a[nlog % 64] <= mem_addr_o;
      log_d[nlog % 64] <= mem_wdata_o;
      nlog <= nlog + 1;
      head <= head + 1;
    end
  end

  dma_req_channel i_dma_req_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .dreq_i(dreq_i), .fifo_level_i(fifo_level_i), .fifo_data_i(fifo_data_i),
    .fifo_pop_o(fifo_pop_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .busy_o(busy_o),
    .irq_o(irq_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic clear_q();
    @(negedge clk_i);
    clr = 1'b1; tail = 0;
    @(negedge clk_i);
    clr = 1'b0;
  endtask

  task automatic push(input int n);
    for (int k = 0; k < n; k++) begin
      fq[tail % 64] = {cid, 8'(tail)};
      tail++;
    end
  endtask

  task automatic pulse_dreq();
    @(negedge clk_i);
    dreq_i = 1'b1;
    @(negedge clk_i);
    dreq_i = 1'b0;
  endtask

  task automatic wait_idle(input bool_exp_busy);
  endtask

  task automatic drain();
    int g = 0;
    while (busy_o && g < 500) begin
      @(negedge clk_i);
      g++;
    end
  endtask

  task automatic setup(input int cnt, input bit ie, input logic [31:0] base);
    wr(A_OPR, 32'd0);
    wr(A_CTL, 32'h0400 | (32'(ie) << 2));
    clear_q();
    wr(A_DAR, base);
    wr(A_TCR, {8'hA5, 24'(cnt)});
    wr(A_OPR, 32'd1);
  endtask

  task automatic run_case(input int cnt, input bit ie, input bit stall);
    logic [31:0] d, base;
    int nreq;
    base = 32'h0010_0000 + 32'(cnt) * 32'h100;
    cid = 8'(cnt);
    stall_mode = stall;
    setup(cnt, ie, base);
    rd(A_TCR, d); chk("R4 count masked at arm", d, 32'(cnt));
    nreq = (cnt + 3) / 4;
    for (int r = 0; r < nreq; r++) begin
      push(4);
      pulse_dreq();
      chk("R11 busy while moving", 32'(busy_o), 32'd1);
      drain();
      if (r < nreq - 1) begin
        chk("R8 batch drained, waiting", 32'(fifo_level_i), 32'd0);
        rd(A_CTL, d); chk("R8 no end flag mid transfer", 32'(d[1]), 32'd0);
        chk("R11 busy low while waiting", 32'(busy_o), 32'd0);
      end
    end
    chk("R7 word count", 32'(nlog), 32'(cnt));
    for (int i = 0; i < cnt; i++) begin
      chk("R7 dest address", log_a[i], base + 32'(2 * i));
      chk("R7 dest data", 32'(log_d[i]), {16'd0, cid, 8'(i)});
    end
    rd(A_DAR, d); chk("R7 final dest", d, base + 32'(2 * cnt));
    rd(A_TCR, d); chk("R9 count zero", d, 32'd0);
    rd(A_CTL, d); chk("R9 end flag", 32'(d[1]), 32'd1);
    chk("R9 irq follows enable", 32'(irq_o), 32'(ie));
    chk("R8 leftover stays queued", 32'(fifo_level_i), 32'(4 * nreq - cnt));
    stall_mode = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    head = 0; tail = 0; nlog = 0;
    repeat (3) @(negedge clk_i);
    // R1
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reset register", d, 32'd0);
    end
    chk("R1 reset busy/irq/req/err", {28'd0, busy_o, irq_o, mem_req_o, cfg_err_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep of counts, interrupt enable and ready stalls
    for (int c = 1; c <= 12; c++) run_case(c, c[0], c[1]);

    // R6: queue depth gating
    cid = 8'h60;
    setup(8, 1'b0, 32'h0020_0000);
    pulse_dreq(); @(negedge clk_i);
    chk("R6 empty queue ignored", {31'd0, busy_o} | 32'(nlog), 32'd0);
    push(3); pulse_dreq(); repeat (3) @(negedge clk_i);
    chk("R6 depth 3 ignored", {31'd0, busy_o} | 32'(nlog), 32'd0);
    push(1); pulse_dreq(); drain();
    chk("R6 depth 4 served", 32'(nlog), 32'd4);
    push(2); pulse_dreq(); repeat (3) @(negedge clk_i);
    chk("R6 depth 2 ignored", 32'(nlog), 32'd4);
    push(2); pulse_dreq(); drain();
    chk("R6 depth 4 served again", 32'(nlog), 32'd8);
    rd(A_CTL, d); chk("R9 end after 8", 32'(d[1]), 32'd1);

    // R2/R3: which writes re-arm an armed, waiting channel
    cid = 8'h70;
    setup(8, 1'b0, 32'h0030_0000);
    wr(A_TCR, 32'hFF00_0003);
    wr(A_OPR, 32'd1);
    rd(A_TCR, d); chk("R2 rewrite of enable no check", d, 32'hFF00_0003);
    wr(A_CTL, 32'h0400);
    rd(A_TCR, d); chk("R3 control write re-arms", d, 32'h0000_0003);
    wr(A_OPR, 32'd0);
    wr(A_TCR, 32'hEE00_0002);
    wr(A_CTL, 32'h0400);
    rd(A_TCR, d); chk("R3 no arm with enable off", d, 32'hEE00_0002);
    wr(A_OPR, 32'd1);
    rd(A_TCR, d); chk("R2 enable edge arms", d, 32'h0000_0002);
    push(4); pulse_dreq(); drain();
    chk("R8 count limits batch", 32'(nlog), 32'd2);
    chk("R8 leftover after short count", 32'(fifo_level_i), 32'd2);

    // R5: every single-bit deviation of the mode field
    for (int b = 0; b < 14; b++) begin
      if (b == 3 || (b >= 8 && b <= 13)) begin
        wr(A_OPR, 32'd0);
        wr(A_CTL, 32'h0400 ^ (32'd1 << b));
        clear_q();
        wr(A_TCR, 32'hDD00_0004);
        wr(A_OPR, 32'd1);
        chk("R5 illegal mode flagged", 32'(cfg_err_o), 32'd1);
        rd(A_TCR, d); chk("R5 illegal mode not armed", d, 32'hDD00_0004);
      end
    end
    push(4); pulse_dreq(); repeat (3) @(negedge clk_i);
    chk("R5 illegal mode moves nothing", 32'(nlog), 32'd0);
    wr(A_CTL, 32'h0000_C4F4);
    chk("R5 error cleared by control write", 32'(cfg_err_o), 32'd0);
    rd(A_TCR, d); chk("R5 bits outside mask ignored", d, 32'h0000_0004);

    // R13: zero masked count
    wr(A_OPR, 32'd0);
    wr(A_CTL, 32'h0404);
    clear_q();
    wr(A_TCR, 32'h7F00_0000);
    wr(A_OPR, 32'd1);
    rd(A_CTL, d); chk("R13 zero count ends at once", 32'(d[1]), 32'd1);
    chk("R13 no words", 32'(nlog), 32'd0);
    chk("R9 irq on zero count", 32'(irq_o), 32'd1);

    // R10: flag clearing semantics
    wr(A_OPR, 32'd0);
    wr(A_CTL, 32'h0406);
    chk("R10 writing one keeps irq", 32'(irq_o), 32'd1);
    rd(A_CTL, d); chk("R10 writing one keeps flag", 32'(d[1]), 32'd1);
    wr(A_CTL, 32'h0404);
    chk("R10 writing zero drops irq", 32'(irq_o), 32'd0);

    // R12: last word and clearing write in one cycle
    cid = 8'h80;
    setup(1, 1'b1, 32'h0040_0000);
    hold_rdy = 1'b1;
    push(4); pulse_dreq();
    @(negedge clk_i);
    chk("R11 busy while stalled", 32'(busy_o), 32'd1);
    wr_en_i = 1'b1; wr_addr_i = A_CTL; wr_data_i = 32'h0404;
    hold_rdy = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    chk("R12 word moved", 32'(nlog), 32'd1);
    rd(A_CTL, d); chk("R12 completion wins flag", 32'(d[1]), 32'd1);
    chk("R12 irq held", 32'(irq_o), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule